// File: doc/BRIEF.md
# External Memory Bank Decoder

This block connects a 32-bit internal request port to a 16-bit parallel external memory port. Each request address is split into a bank number (the four bits above a 256 MB offset) and an offset. One bank serves up to four NOR or PSRAM devices. Two offset bits choose which of four active-low chip selects is driven. Another bank serves a NAND region through its own select. Requests to any other bank, or to a region that is turned off, get an error response and touch no pin.

For each access the block produces the active-low byte-lane strobes, repeats a byte write onto both data lanes, and on reads moves the addressed byte down to bits [7:0]. Each sub-bank has a configuration bit saying whether its device has byte strobes. A device without them cannot take a single-byte write, so that request is refused. A gap setting either lets a chip select stay low between back-to-back accesses to the same device, or forces it high for a number of cycles between accesses, as devices such as FRAM need.

The request side uses a valid/ready handshake. The requester holds `req_valid` and the request fields stable until `rsp_ready` pulses for one cycle.

Top module: `ext_mem_decoder`

## Requirements
- R1: When address bits [31:28] equal 4'h6 the access goes to a NOR/PSRAM device. Address bits [27:26] pick `mem_ne_n[k]`, driven low during the access. When bits [31:28] equal 4'h8 the access drives `mem_nand_n` low instead. In both cases `mem_addr` carries address bits [27:1].
- R2: At most one of the five selects (`mem_ne_n[3:0]`, `mem_nand_n`) is low at any time. All of them are high after reset and while no access is in progress.
- R3: An access to any other bank, to a sub-bank whose `cfg_sub_en` bit is 0, or to the NAND bank while `cfg_nand_en` is 0 completes with `rsp_ready` and `rsp_err` both 1. No select goes low for it.
- R4: `req_size` 0 means one byte and 1 means a 16-bit halfword. A halfword request with address bit 0 set, or a request with size 2 or 3, completes with an error response.
- R5: A write to a sub-bank whose `cfg_sub_bytesel` bit is 1 drives `mem_nbl_n` as follows: 2'b10 for a byte at an even address, 2'b01 for a byte at an odd address, and 2'b00 for a halfword. `mem_we_n` is low only during the access cycle, and always together with a select.
- R6: Every read drives `mem_nbl_n` to 2'b00, whatever the size or device type.
- R7: A byte write to a sub-bank whose `cfg_sub_bytesel` bit is 0, or to the NAND bank, gets an error response. A halfword write there proceeds with `mem_nbl_n` = 2'b00. Byte writes place `req_wdata[7:0]` on both lanes of `mem_wdata`.
- R8: A byte read returns {8'h00, high byte of `mem_rdata`} when address bit 0 is 1, and {8'h00, low byte} when it is 0. A halfword read returns all 16 bits.
- R9: A valid request accepted at a clock edge drives the device during the next cycle, and `rsp_ready` is high for exactly one cycle after that. An error response raises `rsp_ready` in the cycle right after acceptance.
- R10: With `cfg_gap` equal to 0, a request presented in the cycle right after `rsp_ready`, to the same select, keeps that select low without a break. A request to a different select releases the old select first.
- R11: With `cfg_gap` equal to N > 0, a select stays high for at least N full cycles between two consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sub_en | input | 4 | Enable for each NOR/PSRAM sub-bank |
| cfg_sub_bytesel | input | 4 | Sub-bank device has byte-lane strobes |
| cfg_nand_en | input | 1 | Enable for the NAND bank |
| cfg_gap | input | 4 | Forced select-high cycles between accesses (0 = keep low) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, others invalid |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion is an error |
| rsp_rdata | output | 16 | Read data, byte steered to [7:0] |
| mem_ne_n | output | 4 | NOR/PSRAM chip selects, active low |
| mem_nand_n | output | 1 | NAND select, active low |
| mem_nbl_n | output | 2 | Byte-lane strobes, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 27 | Halfword address within bank |
| mem_wdata | output | 16 | Data to device |
| mem_rdata | input | 16 | Data from device |

## Verification
The bench goes after the lane codes for even and odd byte writes. A design that swapped them would corrupt the neighbouring byte. It checks that reads always open both lanes and that the odd/even byte is steered correctly from both device kinds; a wrong steer returns the other byte. Error paths are probed for stray select pulses: a disabled sub-bank, an unmapped bank, a misaligned halfword, and a byte write to a device without strobes. Back-to-back sequences measure how long the select stays high. A design that ignored the gap would glitch FRAM-style parts, and one that held a select across a change of target would drive two devices.

// File: rtl/emd_pkg.sv
package emd_pkg;

  localparam int unsigned DATA_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_DONE,
    ST_ERR,
    ST_GAP
  } seq_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // Active-low lane strobe pattern for one access.
  function automatic logic [1:0] lane_mask_n(input logic is_write,
                                             input logic is_byte,
                                             input logic a0);
    if (!is_write || !is_byte) return 2'b00;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  // Move the addressed byte of a fetched word to the low lane.
  function automatic logic [DATA_W-1:0] steer_read(input logic [DATA_W-1:0] word,
                                                   input logic is_byte,
                                                   input logic a0);
    if (!is_byte) return word;
    return a0 ? {8'h00, word[15:8]} : {8'h00, word[7:0]};
  endfunction

  // Byte writes are repeated on both lanes.
  function automatic logic [DATA_W-1:0] pack_write(input logic [DATA_W-1:0] data,
                                                   input logic is_byte);
    return is_byte ? {data[7:0], data[7:0]} : data;
  endfunction

endpackage

// File: rtl/emd_decode.sv
module emd_decode #(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned SUB_W     = 2,
  parameter int unsigned NOR_BANK  = 6,
  parameter int unsigned NAND_BANK = 8,
  localparam int unsigned NUM_SUB  = 1 << SUB_W
) (
  input  logic [SEL_W-1:0]   bank,
  input  logic [SUB_W-1:0]   sub,
  input  logic               a0,
  input  logic               is_write,
  input  logic [1:0]         size,
  input  logic [NUM_SUB-1:0] cfg_sub_en,
  input  logic [NUM_SUB-1:0] cfg_sub_bytesel,
  input  logic               cfg_nand_en,
  output logic [NUM_SUB:0]   tgt,
  output logic               dec_err
);
  import emd_pkg::*;

  logic is_nor, is_nand, size_ok, map_ok, lane_ok, bytesel;

  assign is_nor  = (bank == SEL_W'(NOR_BANK));
  assign is_nand = (bank == SEL_W'(NAND_BANK));
  assign size_ok = (size == SZ_BYTE) || ((size == SZ_HALF) && !a0);
  assign bytesel = is_nor & cfg_sub_bytesel[sub];
  assign map_ok  = (is_nor && cfg_sub_en[sub]) || (is_nand && cfg_nand_en);
  assign lane_ok = !(is_write && (size == SZ_BYTE) && !bytesel);
  assign dec_err = !(map_ok && size_ok && lane_ok);

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
    assign tgt[i] = is_nor && (sub == SUB_W'(i));
  end
  assign tgt[NUM_SUB] = is_nand;

endmodule

// File: rtl/emd_lanes.sv
module emd_lanes (
  input  logic        act,
  input  logic        is_write,
  input  logic        is_byte,
  input  logic        a0,
  input  logic [15:0] wdata,
  input  logic [15:0] rdata_in,
  output logic [1:0]  nbl_n,
  output logic [15:0] wdata_out,
  output logic [15:0] rdata_steer
);
  import emd_pkg::*;

  assign nbl_n       = act ? lane_mask_n(is_write, is_byte, a0) : 2'b11;
  assign wdata_out   = pack_write(wdata, is_byte);
  assign rdata_steer = steer_read(rdata_in, is_byte, a0);

endmodule

// File: rtl/emd_seq.sv
module emd_seq #(
  parameter int unsigned TGT_W = 5,
  parameter int unsigned GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             dec_err,
  input  logic [TGT_W-1:0] tgt,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             accept,
  output logic             evt_act,
  output logic             evt_done,
  output logic             evt_err,
  output logic             evt_hold,
  output logic [TGT_W-1:0] sel_on
);
  import emd_pkg::*;

  seq_state_t       state_q, state_d;
  logic [GAP_W-1:0] cnt_q;
  logic [TGT_W-1:0] cur_tgt_q, last_tgt_q;
  logic             last_v_q;
  logic             idle;

  assign idle     = (state_q == ST_IDLE);
  assign accept   = idle && req_valid;
  assign evt_hold = accept && last_v_q && !dec_err && (tgt == last_tgt_q) &&
                    (cfg_gap == '0);
  assign evt_act  = (state_q == ST_ACT);
  assign evt_done = (state_q == ST_DONE);
  assign evt_err  = (state_q == ST_ERR);

  always_comb begin
    if (evt_act || evt_done) sel_on = cur_tgt_q;
    else if (evt_hold)       sel_on = tgt;
    else                     sel_on = '0;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = dec_err ? ST_ERR : ST_ACT;
      ST_ACT:  state_d = ST_DONE;
      ST_DONE: state_d = (cfg_gap != '0) ? ST_GAP : ST_IDLE;
      ST_ERR:  state_d = ST_IDLE;
      ST_GAP:  if (cnt_q <= GAP_W'(1)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      cur_tgt_q  <= '0;
      last_tgt_q <= '0;
      last_v_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept && !dec_err) cur_tgt_q <= tgt;
      if (evt_done) begin
        cnt_q      <= cfg_gap;
        last_tgt_q <= cur_tgt_q;
        last_v_q   <= (cfg_gap == '0);
      end else if (state_q == ST_GAP) begin
        cnt_q <= cnt_q - GAP_W'(1);
      end
      if (idle) last_v_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ext_mem_decoder.sv
module ext_mem_decoder #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFFS_W    = 28,
  parameter int unsigned SUB_W     = 2,
  parameter int unsigned GAP_W     = 4,
  parameter int unsigned NOR_BANK  = 6,
  parameter int unsigned NAND_BANK = 8,
  localparam int unsigned NUM_SUB  = 1 << SUB_W,
  localparam int unsigned SEL_W    = ADDR_W - OFFS_W,
  localparam int unsigned MADDR_W  = OFFS_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SUB-1:0] cfg_sub_en,
  input  logic [NUM_SUB-1:0] cfg_sub_bytesel,
  input  logic               cfg_nand_en,
  input  logic [GAP_W-1:0]   cfg_gap,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [15:0]        req_wdata,
  output logic               rsp_ready,
  output logic               rsp_err,
  output logic [15:0]        rsp_rdata,
  output logic [NUM_SUB-1:0] mem_ne_n,
  output logic               mem_nand_n,
  output logic [1:0]         mem_nbl_n,
  output logic               mem_we_n,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [15:0]        mem_wdata,
  input  logic [15:0]        mem_rdata
);
  import emd_pkg::*;

  logic [NUM_SUB:0]    tgt, sel_on;
  logic                dec_err, accept;
  logic                evt_act, evt_done, evt_err, evt_hold;
  logic [OFFS_W-1:0]   off_q;
  logic                wr_q, byte_q;
  logic [15:0]         wdata_q, rdata_q, rd_steer;

  emd_decode #(
    .SEL_W(SEL_W), .SUB_W(SUB_W), .NOR_BANK(NOR_BANK), .NAND_BANK(NAND_BANK)
  ) u_dec (
    .bank            (req_addr[ADDR_W-1:OFFS_W]),
    .sub             (req_addr[OFFS_W-1 -: SUB_W]),
    .a0              (req_addr[0]),
    .is_write        (req_write),
    .size            (req_size),
    .cfg_sub_en      (cfg_sub_en),
    .cfg_sub_bytesel (cfg_sub_bytesel),
    .cfg_nand_en     (cfg_nand_en),
    .tgt             (tgt),
    .dec_err         (dec_err)
  );

  emd_seq #(.TGT_W(NUM_SUB + 1), .GAP_W(GAP_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .dec_err   (dec_err),
    .tgt       (tgt),
    .cfg_gap   (cfg_gap),
    .accept    (accept),
    .evt_act   (evt_act),
    .evt_done  (evt_done),
    .evt_err   (evt_err),
    .evt_hold  (evt_hold),
    .sel_on    (sel_on)
  );

  emd_lanes u_lanes (
    .act         (evt_act),
    .is_write    (wr_q),
    .is_byte     (byte_q),
    .a0          (off_q[0]),
    .wdata       (wdata_q),
    .rdata_in    (mem_rdata),
    .nbl_n       (mem_nbl_n),
    .wdata_out   (mem_wdata),
    .rdata_steer (rd_steer)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept && !dec_err) begin
        off_q   <= req_addr[OFFS_W-1:0];
        wr_q    <= req_write;
        byte_q  <= (req_size == SZ_BYTE);
        wdata_q <= req_wdata;
      end
      if (evt_act && !wr_q) rdata_q <= rd_steer;
    end
  end

  assign mem_ne_n   = ~sel_on[NUM_SUB-1:0];
  assign mem_nand_n = ~sel_on[NUM_SUB];
  assign mem_we_n   = !(evt_act && wr_q);
  assign mem_addr   = off_q[OFFS_W-1:1];
  assign rsp_ready  = evt_done || evt_err;
  assign rsp_err    = evt_err;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/emd_chk.sv
module emd_chk #(
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned GAP_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [GAP_W-1:0]   cfg_gap,
  input logic               rsp_ready,
  input logic [NUM_SUB-1:0] mem_ne_n,
  input logic               mem_nand_n,
  input logic [1:0]         mem_nbl_n,
  input logic               mem_we_n,
  input logic               evt_act,
  input logic               evt_done,
  input logic               evt_err,
  input logic               evt_hold
);
  logic none_sel;
  assign none_sel = (&mem_ne_n) && mem_nand_n;

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~mem_ne_n, ~mem_nand_n}));

  // R3
  err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> none_sel);

  // R6
  rd_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_act && mem_we_n) |-> (mem_nbl_n == 2'b00));

  // R5
  we_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !none_sel);

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  // R11
  gap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && (cfg_gap != '0)) |=> none_sel);

  // R10
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hold |-> !none_sel);

endmodule

bind ext_mem_decoder emd_chk #(.NUM_SUB(NUM_SUB), .GAP_W(GAP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_gap    (cfg_gap),
  .rsp_ready  (rsp_ready),
  .mem_ne_n   (mem_ne_n),
  .mem_nand_n (mem_nand_n),
  .mem_nbl_n  (mem_nbl_n),
  .mem_we_n   (mem_we_n),
  .evt_act    (evt_act),
  .evt_done   (evt_done),
  .evt_err    (evt_err),
  .evt_hold   (evt_hold)
);

// File: tb/sim_ext_mem_decoder.sv
`timescale 1ns/1ps
module sim_ext_mem_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_sub_en = 4'b1011;
  logic [3:0]  cfg_sub_bytesel = 4'b0101;
  logic        cfg_nand_en = 1'b1;
  logic [3:0]  cfg_gap = 4'd0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_ready, rsp_err;
  logic [15:0] rsp_rdata;
  logic [3:0]  mem_ne_n;
  logic        mem_nand_n;
  logic [1:0]  mem_nbl_n;
  logic        mem_we_n;
  logic [26:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'hBEEF;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ext_mem_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sub_en(cfg_sub_en), .cfg_sub_bytesel(cfg_sub_bytesel),
    .cfg_nand_en(cfg_nand_en), .cfg_gap(cfg_gap), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mem_ne_n(mem_ne_n), .mem_nand_n(mem_nand_n),
    .mem_nbl_n(mem_nbl_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Captured view of one access
  logic [3:0]  o_ne;
  logic        o_nand, o_we, o_err;
  logic [1:0]  o_nbl;
  logic [26:0] o_addr;
  logic [15:0] o_wd, o_rd;

  task automatic run_req(input logic w, input logic [31:0] a, input logic [1:0] sz,
                         input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    o_ne = mem_ne_n; o_nand = mem_nand_n; o_we = mem_we_n; o_nbl = mem_nbl_n;
    o_addr = mem_addr; o_wd = mem_wdata;
    if (rsp_ready) begin
      o_err = rsp_err; o_rd = 16'h0;
    end else begin
      @(negedge clk);
      chk("R9 ready two cycles after accept", {31'h0, rsp_ready}, 32'h1);
      o_err = rsp_err; o_rd = rsp_rdata;
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 reset ne_n", {28'h0, mem_ne_n}, 32'hF);
    chk("R2 reset nand_n", {31'h0, mem_nand_n}, 32'h1);
    chk("R9 reset ready", {31'h0, rsp_ready}, 32'h0);
  endtask

  task automatic t_decode;
    run_req(1'b0, 32'h6000_0010, 2'd1, 16'h0);
    chk("R1 sub0 select", {28'h0, o_ne}, 32'hE);
    chk("R1 sub0 addr", {5'h0, o_addr}, 32'h8);
    chk("R1 sub0 no err", {31'h0, o_err}, 32'h0);
    run_req(1'b0, 32'h6C00_0024, 2'd1, 16'h0);
    chk("R1 sub3 select", {28'h0, o_ne}, 32'h7);
    chk("R1 sub3 addr", {5'h0, o_addr}, 32'h0600_0012);
    run_req(1'b0, 32'h8000_0100, 2'd1, 16'h0);
    chk("R1 nand select", {31'h0, o_nand}, 32'h0);
    chk("R1 nand no ne", {28'h0, o_ne}, 32'hF);
    @(negedge clk);
    chk("R2 idle all high", {27'h0, mem_ne_n, mem_nand_n}, 32'h1F);
  endtask

  task automatic t_errors;
    run_req(1'b0, 32'h7000_0000, 2'd1, 16'h0);
    chk("R3 unmapped err", {31'h0, o_err}, 32'h1);
    chk("R3 unmapped no sel", {27'h0, o_ne, o_nand}, 32'h1F);
    run_req(1'b0, 32'h6800_0000, 2'd1, 16'h0);
    chk("R3 disabled sub err", {31'h0, o_err}, 32'h1);
    chk("R3 disabled sub no sel", {27'h0, o_ne, o_nand}, 32'h1F);
    cfg_nand_en = 1'b0;
    run_req(1'b0, 32'h8000_0000, 2'd1, 16'h0);
    chk("R3 nand off err", {31'h0, o_err}, 32'h1);
    chk("R3 nand off no sel", {31'h0, o_nand}, 32'h1);
    cfg_nand_en = 1'b1;
    run_req(1'b0, 32'h6000_0001, 2'd1, 16'h0);
    chk("R4 misaligned half err", {31'h0, o_err}, 32'h1);
    run_req(1'b0, 32'h6000_0000, 2'd2, 16'h0);
    chk("R4 size2 err", {31'h0, o_err}, 32'h1);
    chk("R4 size2 no sel", {27'h0, o_ne, o_nand}, 32'h1F);
  endtask

  task automatic t_writes;
    run_req(1'b1, 32'h6000_0020, 2'd0, 16'h00A5);
    chk("R5 even byte lanes", {30'h0, o_nbl}, 32'h2);
    chk("R5 we low", {31'h0, o_we}, 32'h0);
    chk("R7 byte replicated", {16'h0, o_wd}, 32'hA5A5);
    run_req(1'b1, 32'h6000_0021, 2'd0, 16'h003C);
    chk("R5 odd byte lanes", {30'h0, o_nbl}, 32'h1);
    run_req(1'b1, 32'h6000_0022, 2'd1, 16'h1234);
    chk("R5 half lanes", {30'h0, o_nbl}, 32'h0);
    chk("R5 half data", {16'h0, o_wd}, 32'h1234);
    @(negedge clk);
    chk("R5 we high after", {31'h0, mem_we_n}, 32'h1);
  endtask

  task automatic t_nobytesel;
    run_req(1'b1, 32'h6400_0002, 2'd0, 16'h0011);
    chk("R7 byte write no-strobe err", {31'h0, o_err}, 32'h1);
    chk("R7 byte write no sel", {28'h0, o_ne}, 32'hF);
    run_req(1'b1, 32'h6400_0002, 2'd1, 16'h5566);
    chk("R7 half write ok", {31'h0, o_err}, 32'h0);
    chk("R7 half write lanes", {30'h0, o_nbl}, 32'h0);
    run_req(1'b1, 32'h8000_0003, 2'd0, 16'h0011);
    chk("R7 nand byte write err", {31'h0, o_err}, 32'h1);
  endtask

  task automatic t_reads;
    mem_rdata = 16'hBEEF;
    run_req(1'b0, 32'h6000_0040, 2'd0, 16'h0);
    chk("R6 byte read lanes", {30'h0, o_nbl}, 32'h0);
    chk("R6 read we high", {31'h0, o_we}, 32'h1);
    chk("R8 even byte", {16'h0, o_rd}, 32'h00EF);
    run_req(1'b0, 32'h6000_0041, 2'd0, 16'h0);
    chk("R8 odd byte", {16'h0, o_rd}, 32'h00BE);
    mem_rdata = 16'h5AC3;
    run_req(1'b0, 32'h6400_0007, 2'd0, 16'h0);
    chk("R6 no-strobe read lanes", {30'h0, o_nbl}, 32'h0);
    chk("R8 no-strobe odd byte", {16'h0, o_rd}, 32'h005A);
    run_req(1'b0, 32'h6400_0006, 2'd1, 16'h0);
    chk("R8 half read", {16'h0, o_rd}, 32'h5AC3);
  endtask

  task automatic t_pulse;
    run_req(1'b0, 32'h6000_0000, 2'd1, 16'h0);
    @(negedge clk);
    chk("R9 ready one cycle", {31'h0, rsp_ready}, 32'h0);
    run_req(1'b0, 32'h7000_0000, 2'd1, 16'h0);
    @(negedge clk);
    chk("R9 err ready one cycle", {31'h0, rsp_ready}, 32'h0);
  endtask

  // Back-to-back on sub0: count sampled cycles with ne_n[0] high between accesses.
  task automatic b2b_same(output int highs);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h6000_0000; req_size = 2'd1;
    for (int i = 0; i < 10 && !rsp_ready; i++) @(negedge clk);
    req_addr = 32'h6000_0002;
    highs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mem_ne_n[0] == 1'b0) break;
      highs++;
    end
    for (int i = 0; i < 10 && !rsp_ready; i++) @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_hold;
    int h;
    cfg_gap = 4'd0;
    b2b_same(h);
    chk("R10 same target no gap", h, 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h6000_0000; req_size = 2'd1;
    for (int i = 0; i < 10 && !rsp_ready; i++) @(negedge clk);
    req_addr = 32'h6C00_0000;
    @(negedge clk);
    chk("R10 switch target releases", {28'h0, mem_ne_n}, 32'hF);
    @(negedge clk);
    chk("R10 new target selected", {28'h0, mem_ne_n}, 32'h7);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_gap;
    int h;
    cfg_gap = 4'd3;
    b2b_same(h);
    chk("R11 gap 3 at least 3 high", {31'h0, h >= 3}, 32'h1);
    cfg_gap = 4'd1;
    b2b_same(h);
    chk("R11 gap 1 at least 1 high", {31'h0, h >= 1}, 32'h1);
    cfg_gap = 4'd0;
  endtask

  logic done = 1'b0;

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_decode;
    t_errors;
    t_writes;
    t_nobytesel;
    t_reads;
    t_pulse;
    t_hold;
    t_gap;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule